// File: doc/BRIEF.md
# Indexed Load Address Generator

This block executes the word-load instructions of a 32-bit core. It takes one instruction word, decides from its condition field whether it runs at all, reads the base register and (for the register-offset forms) an offset register, and forms an effective address. It then issues one memory read and writes the returned word into the destination register. The write-back forms also replace the base register with base plus offset. For the pre-indexed forms, the access uses that sum. For the post-indexed form, it uses the untouched base.

The register file and the memory live outside the block. Register reads go through two combinational read ports. Register writes go through a single write port, one write per cycle. The memory is a request/acknowledge read port with an error flag. The condition evaluator is also outside the block and presents a 16-bit vector with one bit per condition code; a set bit means that condition currently holds.

Control is a state machine with seven states:
- `ST_IDLE`: waits for an instruction and is the only state that reports ready.
- `ST_OPERAND`: latches the effective address and the updated base from the register read ports.
- `ST_ACCESS`: holds the memory request until it is acknowledged.
- `ST_BASE_WB`: writes the updated base register.
- `ST_DATA_WB`: writes the loaded word.
- `ST_SKIP`: closes a condition-failed instruction.
- `ST_FAULT`: reports a failed access.

Transitions:
- `ST_IDLE` goes to `ST_OPERAND` on a legal load whose condition holds, and to `ST_SKIP` on a legal load whose condition fails.
- `ST_OPERAND` always goes to `ST_ACCESS`.
- `ST_ACCESS` stays until acknowledged. On acknowledge it goes to `ST_FAULT` on error, to `ST_BASE_WB` for write-back forms, and otherwise to `ST_DATA_WB`.
- `ST_BASE_WB` always goes to `ST_DATA_WB`.
- `ST_DATA_WB`, `ST_SKIP` and `ST_FAULT` each return to `ST_IDLE`.

Top module: `ldg_load_unit`

## Requirements
- R1: Only opcode values 1 to 6 in instruction bits [6:0] are taken. Any other opcode presented while ready is ignored: the block stays ready, makes no memory request, no register write and no done pulse.
- R2: Bits [10:7] select one bit of `cond_hold`. If that bit is 0, the block pulses `done` in the cycle after acceptance, with no memory request and no register write.
- R3: Opcodes 1, 2 and 3 take an 11-bit unsigned offset from bits [31:21] and scale it by 4, giving byte offsets from 0 to 8188.
- R4: Opcodes 4, 5 and 6 take the offset from the register indexed by bits [25:21] (read port B). Bits [31:26] have no effect.
- R5: Opcodes 1 and 4 read memory at base plus offset and write only the destination register (bits [15:11]). The base register (bits [20:16], read port A) is left unchanged.
- R6: Opcodes 2 and 5 read memory at base plus offset and also write base plus offset into the base register.
- R7: Opcodes 3 and 6 read memory at the unmodified base and then write base plus offset into the base register.
- R8: A memory request starts in the second cycle after acceptance. It is held with a stable address until acknowledged, and each instruction issues exactly one request.
- R9: An acknowledge with the error flag set makes the block pulse `fault` together with `done` in the next cycle. No register is written: neither the destination nor the base.
- R10: The base write, when present, comes one cycle before the data write. The data write carries `done`, so when the destination equals the base register, the loaded word is what remains.
- R11: After reset the block is ready, with no request, no write, no done and no fault.
- R12: Address and base arithmetic wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 32 | Instruction word |
| instr_ready | output | 1 | Block idle and able to take an instruction |
| cond_hold | input | 16 | One bit per condition code, set when that condition holds |
| rf_a_idx | output | 5 | Read port A index (base register) |
| rf_a_data | input | 32 | Read port A data |
| rf_b_idx | output | 5 | Read port B index (offset register) |
| rf_b_data | input | 32 | Read port B data |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_err | input | 1 | Access failed, valid with acknowledge |
| done | output | 1 | Instruction finished |
| fault | output | 1 | Memory fault on the finished instruction |

## Verification
The bench attacks the following corner cases:
- Pre-indexed versus post-indexed addressing. A swap would put the request on the wrong address.
- The largest immediate (2047 scaled to 8188). A missing scale or a signed field would miss it.
- Junk in bits [31:26] of a register-offset form. Decoding those bits as part of the offset would corrupt the address.
- A write-back load whose destination equals its base register. Writing the data before the base would leave the updated base behind.
- A faulting write-back. It must change no register, whereas a design that commits early would move the base.
- A condition-failed load. It must stay silent on memory.
- Illegal opcodes. They must leave the block ready.
- Base arithmetic that wraps past 2^32.
- Acknowledge latencies of zero to three cycles. A request that drops or moves while waiting shows up in the per-cycle comparison.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 7;
    localparam int COND_W    = 4;
    localparam int RIDX_W    = 5;
    localparam int IMM_W     = 11;

    localparam int COND_LSB  = 7;
    localparam int DST_LSB   = 11;
    localparam int SRC_LSB   = 16;
    localparam int OFFR_LSB  = 21;
    localparam int IMM_LSB   = 21;

    localparam logic [OPC_W-1:0] OPC_IMM_PRE     = 7'h01;
    localparam logic [OPC_W-1:0] OPC_IMM_PRE_WB  = 7'h02;
    localparam logic [OPC_W-1:0] OPC_IMM_POST_WB = 7'h03;
    localparam logic [OPC_W-1:0] OPC_REG_PRE     = 7'h04;
    localparam logic [OPC_W-1:0] OPC_REG_PRE_WB  = 7'h05;
    localparam logic [OPC_W-1:0] OPC_REG_POST_WB = 7'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPERAND,
        ST_ACCESS,
        ST_BASE_WB,
        ST_DATA_WB,
        ST_SKIP,
        ST_FAULT
    } ldg_state_e;

    typedef struct packed {
        logic              legal;
        logic              reg_off;
        logic              write_back;
        logic              post_index;
        logic [COND_W-1:0] cond;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src;
        logic [RIDX_W-1:0] off_reg;
        logic [IMM_W-1:0]  imm;
    } ldg_op_t;

endpackage

// File: rtl/ldg_decode.sv
module ldg_decode
    import ldg_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ldg_op_t            op_o
);

    logic [OPC_W-1:0] opc;

    assign opc = instr_i[OPC_W-1:0];

    always_comb begin
        op_o.legal      = 1'b0;
        op_o.reg_off    = 1'b0;
        op_o.write_back = 1'b0;
        op_o.post_index = 1'b0;
        unique case (opc)
            OPC_IMM_PRE: begin
                op_o.legal = 1'b1;
            end
            OPC_IMM_PRE_WB: begin
                op_o.legal      = 1'b1;
                op_o.write_back = 1'b1;
            end
            OPC_IMM_POST_WB: begin
                op_o.legal      = 1'b1;
                op_o.write_back = 1'b1;
                op_o.post_index = 1'b1;
            end
            OPC_REG_PRE: begin
                op_o.legal   = 1'b1;
                op_o.reg_off = 1'b1;
            end
            OPC_REG_PRE_WB: begin
                op_o.legal      = 1'b1;
                op_o.reg_off    = 1'b1;
                op_o.write_back = 1'b1;
            end
            OPC_REG_POST_WB: begin
                op_o.legal      = 1'b1;
                op_o.reg_off    = 1'b1;
                op_o.write_back = 1'b1;
                op_o.post_index = 1'b1;
            end
            default: begin
                op_o.legal = 1'b0;
            end
        endcase
        op_o.cond    = instr_i[COND_LSB +: COND_W];
        op_o.dst     = instr_i[DST_LSB  +: RIDX_W];
        op_o.src     = instr_i[SRC_LSB  +: RIDX_W];
        op_o.off_reg = instr_i[OFFR_LSB +: RIDX_W];
        op_o.imm     = instr_i[IMM_LSB  +: IMM_W];
    end

endmodule

// File: rtl/ldg_agen.sv
module ldg_agen #(
    parameter int WORD_W    = 32,
    parameter int IMM_W     = 11,
    parameter int IMM_SHIFT = 2
) (
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] reg_off_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_reg_i,
    input  logic              post_i,
    output logic [WORD_W-1:0] access_addr_o,
    output logic [WORD_W-1:0] next_base_o
);

    localparam int SCALED_W = IMM_W + IMM_SHIFT;

    logic [WORD_W-1:0]   imm_off;
    logic [WORD_W-1:0]   offset;
    logic [SCALED_W-1:0] scaled;

    assign scaled = {imm_i, {IMM_SHIFT{1'b0}}};

    generate
        if (SCALED_W >= WORD_W) begin : g_imm_trunc
            assign imm_off = scaled[WORD_W-1:0];
        end else begin : g_imm_ext
            assign imm_off = {{(WORD_W-SCALED_W){1'b0}}, scaled};
        end
    endgenerate

    assign offset        = use_reg_i ? reg_off_i : imm_off;
    assign next_base_o   = base_i + offset;
    assign access_addr_o = post_i ? base_i : next_base_o;

endmodule

// File: rtl/ldg_ctrl.sv
module ldg_ctrl
    import ldg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic legal_i,
    input  logic cond_ok_i,
    input  logic write_back_i,
    input  logic mem_ack_i,
    input  logic mem_err_i,
    output logic ready_o,
    output logic take_instr_o,
    output logic take_operands_o,
    output logic take_rdata_o,
    output logic mem_req_o,
    output logic we_base_o,
    output logic we_data_o,
    output logic done_o,
    output logic fault_o
);

    ldg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && legal_i) begin
                    state_d = cond_ok_i ? ST_OPERAND : ST_SKIP;
                end
            end
            ST_OPERAND: state_d = ST_ACCESS;
            ST_ACCESS: begin
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        state_d = ST_FAULT;
                    end else if (write_back_i) begin
                        state_d = ST_BASE_WB;
                    end else begin
                        state_d = ST_DATA_WB;
                    end
                end
            end
            ST_BASE_WB: state_d = ST_DATA_WB;
            ST_DATA_WB: state_d = ST_IDLE;
            ST_SKIP:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o         = 1'b0;
        take_instr_o    = 1'b0;
        take_operands_o = 1'b0;
        take_rdata_o    = 1'b0;
        mem_req_o       = 1'b0;
        we_base_o       = 1'b0;
        we_data_o       = 1'b0;
        done_o          = 1'b0;
        fault_o         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o      = 1'b1;
                take_instr_o = start_i && legal_i;
            end
            ST_OPERAND: take_operands_o = 1'b1;
            ST_ACCESS: begin
                mem_req_o    = 1'b1;
                take_rdata_o = mem_ack_i;
            end
            ST_BASE_WB: we_base_o = 1'b1;
            ST_DATA_WB: begin
                we_data_o = 1'b1;
                done_o    = 1'b1;
            end
            ST_SKIP: done_o = 1'b1;
            ST_FAULT: begin
                done_o  = 1'b1;
                fault_o = 1'b1;
            end
            default: ready_o = 1'b0;
        endcase
    end

    assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    assert_base_then_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_base_o |=> (we_data_o && done_o));

endmodule

// File: rtl/ldg_load_unit.sv
module ldg_load_unit
    import ldg_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int IMM_SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_valid,
    input  logic [INSTR_W-1:0]      instr,
    output logic                    instr_ready,
    input  logic [(1<<COND_W)-1:0]  cond_hold,
    output logic [RIDX_W-1:0]       rf_a_idx,
    input  logic [WORD_W-1:0]       rf_a_data,
    output logic [RIDX_W-1:0]       rf_b_idx,
    input  logic [WORD_W-1:0]       rf_b_data,
    output logic                    rf_we,
    output logic [RIDX_W-1:0]       rf_widx,
    output logic [WORD_W-1:0]       rf_wdata,
    output logic                    mem_req,
    output logic [WORD_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [WORD_W-1:0]       mem_rdata,
    input  logic                    mem_err,
    output logic                    done,
    output logic                    fault
);

    ldg_op_t           dec;
    logic              cond_ok;
    logic              take_instr, take_operands, take_rdata;
    logic              we_base, we_data;

    logic [RIDX_W-1:0] dst_q, src_q, offr_q;
    logic [IMM_W-1:0]  imm_q;
    logic              reg_off_q, wb_q, post_q;
    logic [WORD_W-1:0] addr_q, nbase_q, rdata_q;
    logic [WORD_W-1:0] agen_addr, agen_nbase;

    ldg_decode u_decode (
        .instr_i (instr),
        .op_o    (dec)
    );

    assign cond_ok = cond_hold[dec.cond];

    ldg_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (instr_valid),
        .legal_i         (dec.legal),
        .cond_ok_i       (cond_ok),
        .write_back_i    (wb_q),
        .mem_ack_i       (mem_ack),
        .mem_err_i       (mem_err),
        .ready_o         (instr_ready),
        .take_instr_o    (take_instr),
        .take_operands_o (take_operands),
        .take_rdata_o    (take_rdata),
        .mem_req_o       (mem_req),
        .we_base_o       (we_base),
        .we_data_o       (we_data),
        .done_o          (done),
        .fault_o         (fault)
    );

    ldg_agen #(
        .WORD_W    (WORD_W),
        .IMM_W     (IMM_W),
        .IMM_SHIFT (IMM_SHIFT)
    ) u_agen (
        .base_i        (rf_a_data),
        .reg_off_i     (rf_b_data),
        .imm_i         (imm_q),
        .use_reg_i     (reg_off_q),
        .post_i        (post_q),
        .access_addr_o (agen_addr),
        .next_base_o   (agen_nbase)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q     <= '0;
            src_q     <= '0;
            offr_q    <= '0;
            imm_q     <= '0;
            reg_off_q <= 1'b0;
            wb_q      <= 1'b0;
            post_q    <= 1'b0;
        end else if (take_instr) begin
            dst_q     <= dec.dst;
            src_q     <= dec.src;
            offr_q    <= dec.off_reg;
            imm_q     <= dec.imm;
            reg_off_q <= dec.reg_off;
            wb_q      <= dec.write_back;
            post_q    <= dec.post_index;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            nbase_q <= '0;
        end else if (take_operands) begin
            addr_q  <= agen_addr;
            nbase_q <= agen_nbase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take_rdata) begin
            rdata_q <= mem_rdata;
        end
    end

    assign rf_a_idx = src_q;
    assign rf_b_idx = offr_q;
    assign mem_addr = addr_q;
    assign rf_we    = we_base | we_data;
    assign rf_widx  = we_base ? src_q : dst_q;
    assign rf_wdata = we_base ? nbase_q : rdata_q;

    assert_illegal_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && !dec.legal) |=> instr_ready);

    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && dec.legal && !cond_ok) |=> (done && !mem_req && !rf_we));

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_fault_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (fault && done && !rf_we));

    assert_fault_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !rf_we));

endmodule

// File: tb/test_ldg_load_unit.sv
module test_ldg_load_unit;

    localparam int W  = 32;
    localparam int VW = 74;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic          instr_ready;
    logic [15:0]   cond_hold = 16'hFFFF;
    logic [4:0]    rf_a_idx, rf_b_idx, rf_widx;
    logic [W-1:0]  rf_a_data, rf_b_data, rf_wdata;
    logic          rf_we, mem_req, mem_ack, mem_err, done, fault;
    logic [W-1:0]  mem_addr, mem_rdata;

    logic [W-1:0]  regs [32];
    logic          pre_we = 1'b0;
    logic [4:0]    pre_idx = '0;
    logic [W-1:0]  pre_val = '0;
    int            lat = 0;
    int            wcnt = 0;
    int            checks = 0;
    int            errors = 0;
    logic [VW-1:0] expq [$];

    always #5 clk = ~clk;

    ldg_load_unit i_ldg_load_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .instr_ready(instr_ready), .cond_hold(cond_hold),
        .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .done(done), .fault(fault)
    );

    function automatic logic [W-1:0] memval(input logic [W-1:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    assign rf_a_data = regs[rf_a_idx];
    assign rf_b_data = regs[rf_b_idx];
    assign mem_ack   = mem_req && (wcnt == lat);
    assign mem_rdata = memval(mem_addr);
    assign mem_err   = (mem_addr[31:28] == 4'hF);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) regs[i] <= 32'h100 * i;
            wcnt <= 0;
        end else begin
            if (mem_req && !mem_ack) wcnt <= wcnt + 1;
            else wcnt <= 0;
            if (rf_we) regs[rf_widx] <= rf_wdata;
            else if (pre_we) regs[pre_idx] <= pre_val;
        end
    end

    function automatic logic [VW-1:0] ev(input logic rdy, input logic rq, input logic [W-1:0] a,
                                         input logic we, input logic [4:0] wi, input logic [W-1:0] wd,
                                         input logic dn, input logic ft);
        return {rdy, rq, rq ? a : 32'h0, we, we ? wi : 5'h0, we ? wd : 32'h0, dn, ft};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (rdy,req,addr,we,idx,data,done,fault)", tag, act, exp);
        end
    endtask

    task automatic set_reg(input logic [4:0] idx, input logic [W-1:0] val);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = idx; pre_val = val;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic issue(input logic [6:0] opc, input logic [3:0] cnd, input logic [4:0] dst,
                         input logic [4:0] src, input logic [10:0] offf, input logic [5:0] junk,
                         input int l, input string tag);
        logic [31:0] word;
        logic [W-1:0] base, off, a, nb, rd;
        bit legal, regf, wb, post, pass, flt;
        logic [VW-1:0] e, act;
        legal = (opc >= 7'd1) && (opc <= 7'd6);
        regf  = (opc >= 7'd4) && (opc <= 7'd6);
        wb    = (opc == 7'd2) || (opc == 7'd3) || (opc == 7'd5) || (opc == 7'd6);
        post  = (opc == 7'd3) || (opc == 7'd6);
        word  = regf ? {junk, offf[4:0], src, dst, cnd, opc} : {offf, src, dst, cnd, opc};
        base  = regs[src];
        off   = regf ? regs[offf[4:0]] : {19'b0, offf, 2'b00};
        nb    = base + off;
        a     = post ? base : nb;
        rd    = memval(a);
        pass  = cond_hold[cnd];
        flt   = (a[31:28] == 4'hF);
        lat   = l;
        if (!legal) begin
            for (int i = 0; i < 3; i++) expq.push_back(ev(1, 0, 0, 0, 0, 0, 0, 0));
        end else if (!pass) begin
            expq.push_back(ev(0, 0, 0, 0, 0, 0, 1, 0));
            expq.push_back(ev(1, 0, 0, 0, 0, 0, 0, 0));
        end else begin
            expq.push_back(ev(0, 0, 0, 0, 0, 0, 0, 0));
            for (int i = 0; i <= l; i++) expq.push_back(ev(0, 1, a, 0, 0, 0, 0, 0));
            if (flt) begin
                expq.push_back(ev(0, 0, 0, 0, 0, 0, 1, 1));
            end else begin
                if (wb) expq.push_back(ev(0, 0, 0, 1, src, nb, 0, 0));
                expq.push_back(ev(0, 0, 0, 1, dst, rd, 1, 0));
            end
            expq.push_back(ev(1, 0, 0, 0, 0, 0, 0, 0));
        end
        @(negedge clk);
        instr = word; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        while (expq.size() > 0) begin
            e   = expq.pop_front();
            act = ev(instr_ready, mem_req, mem_addr, rf_we, rf_widx, rf_wdata, done, fault);
            check(act == e, tag, act, e);
            if (expq.size() > 0) @(negedge clk);
        end
    endtask

    task automatic check_reg(input logic [4:0] idx, input logic [W-1:0] exp, input string tag);
        checks++;
        if (regs[idx] !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, regs[idx], exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] exp_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check({instr_ready, mem_req, rf_we, done, fault} == 5'b10000, "R11",
              {69'b0, instr_ready, mem_req, rf_we, done, fault}, 74'b10000);

        // R3 R5: immediate pre-indexed, no write-back
        set_reg(5'd2, 32'h0000_1000);
        issue(7'h01, 4'd0, 5'd3, 5'd2, 11'd2, 6'd0, 0, "R3_R5 imm pre");
        check_reg(5'd2, 32'h0000_1000, "R5 base kept");
        // R3: largest immediate 2047 -> 8188
        issue(7'h01, 4'd1, 5'd4, 5'd2, 11'd2047, 6'd0, 1, "R3 max imm");
        // R6 R8: pre-indexed write-back with wait states
        issue(7'h02, 4'd2, 5'd5, 5'd2, 11'd3, 6'd0, 2, "R6_R8 imm pre wb");
        check_reg(5'd2, 32'h0000_100C, "R6 base updated");
        // R7: post-indexed immediate
        issue(7'h03, 4'd3, 5'd6, 5'd2, 11'd1, 6'd0, 1, "R7 imm post wb");
        check_reg(5'd2, 32'h0000_1010, "R7 base updated");
        // R4 R5: register offset with junk in [31:26]
        set_reg(5'd9, 32'h0000_0024);
        issue(7'h04, 4'd0, 5'd10, 5'd2, 11'd9, 6'h3F, 0, "R4_R5 reg pre");
        issue(7'h05, 4'd0, 5'd11, 5'd2, 11'd9, 6'h2A, 3, "R4_R6 reg pre wb");
        issue(7'h06, 4'd0, 5'd12, 5'd2, 11'd9, 6'h15, 0, "R4_R7 reg post wb");
        // R2: condition fails, then a passing one
        cond_hold = 16'hFFFF ^ (16'h1 << 5);
        issue(7'h02, 4'd5, 5'd13, 5'd2, 11'd1, 6'd0, 0, "R2 cond fail");
        issue(7'h01, 4'd6, 5'd13, 5'd2, 11'd1, 6'd0, 0, "R2 cond pass");
        cond_hold = 16'hFFFF;
        // R9: faulting write-back leaves registers alone
        set_reg(5'd14, 32'hF000_0000);
        set_reg(5'd15, 32'h1111_2222);
        issue(7'h05, 4'd0, 5'd15, 5'd14, 11'd9, 6'd0, 1, "R9 fault");
        check_reg(5'd14, 32'hF000_0000, "R9 base kept");
        check_reg(5'd15, 32'h1111_2222, "R9 dst kept");
        // R10: dst equals base, data wins
        set_reg(5'd7, 32'h0000_2000);
        exp_rd = memval(32'h0000_2000);
        issue(7'h03, 4'd0, 5'd7, 5'd7, 11'd4, 6'd0, 0, "R10 dst==src");
        check_reg(5'd7, exp_rd, "R10 data wins");
        // R12: wraparound
        set_reg(5'd20, 32'hFFFF_FFF8);
        issue(7'h02, 4'd0, 5'd21, 5'd20, 11'd4, 6'd0, 0, "R12 wrap");
        check_reg(5'd20, 32'h0000_0008, "R12 base wrapped");
        // R1: illegal opcodes ignored
        issue(7'h00, 4'd0, 5'd22, 5'd2, 11'd1, 6'd0, 0, "R1 opc 0");
        issue(7'h07, 4'd0, 5'd22, 5'd2, 11'd1, 6'd0, 0, "R1 opc 7");
        issue(7'h7F, 4'd0, 5'd22, 5'd2, 11'd1, 6'd0, 0, "R1 opc 7F");
        check_reg(5'd22, 32'h100 * 22, "R1 dst untouched");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule